// File: doc/BRIEF.md
# Region-Based Memory Protection Unit

This block decides, for every instruction fetch and every data access a processor makes, whether the access may proceed and how the memory system should treat it. Eight regions are held entirely in on-chip registers; nothing is fetched from memory to describe them. Each region has a power-of-two size from 4 KB up to the whole 4 GB address space, an enable bit, and two attribute sets. One set applies to instruction fetches and the other to data reads and writes. Each set holds a cacheable bit, a bufferable (write-buffer) bit and a two-bit permission code.

The lookup path is purely combinational. An address, a privilege flag and an access kind go in. In the same cycle the block returns an abort flag and the cacheable and bufferable attributes of the region that governs the address. When regions overlap, the highest-numbered enabled region governs. An address covered by no enabled region aborts. Software programs the regions through a simple write port. Each write carries a region index, a word selector and a data word, and it takes effect at the next rising clock edge.

Top module: `mpu_region_check`

## Requirements
- R1: After reset every region is disabled, so every lookup returns abort=1, cacheable=0 and bufferable=0.
- R2: A geometry write (selector 0) takes its enable from data bit 0, its size exponent s from bits [6:1], and its base from bits [31:12]. A region covers the aligned 2^s-byte block that contains the base. Base bits below s are ignored, an s below 12 acts as 12, and an s above 32 acts as 32.
- R3: When several enabled regions contain the address, the highest-numbered one supplies the permission and attributes. Disabling that region hands the address back to the next lower region that contains it.
- R4: An access whose address lies in no enabled region aborts.
- R5: The permission code takes one of four values:
  - 0: every access aborts.
  - 1: privileged accesses are allowed and user accesses abort.
  - 2: privileged accesses are allowed, and user reads and fetches are allowed while user writes abort.
  - 3: every access is allowed.
  The abort is reported combinationally, in the same cycle as the lookup.
- R6: An attribute word holds permission in bits [1:0], cacheable in bit 2 and bufferable in bit 3. Selector 1 writes the instruction set, which governs access kind 2 (fetch). Selector 2 writes the data set, which governs kind 0 (read) and kind 1 (write).
- R7: Whenever abort is 1, cacheable and bufferable are both 0.
- R8: Access kind 3 is reserved and always aborts.
- R9: A configuration write with selector 3 changes no region state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Region index written |
| cfg_sel | input | 2 | Word selector: 0 geometry, 1 instruction attributes, 2 data attributes, 3 none |
| cfg_wdata | input | 32 | Configuration data word |
| req_addr | input | 32 | Lookup address |
| req_priv | input | 1 | 1 = privileged access, 0 = user access |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 reserved |
| rsp_abort | output | 1 | Access must be aborted |
| rsp_cacheable | output | 1 | Governing region marks the access cacheable |
| rsp_bufferable | output | 1 | Governing region allows write buffering |

## Verification
The hardest case to reach from the ports is a three-deep overlap. In it a full-address-space region, reached only through an out-of-range size exponent, sits above two nested smaller regions. Its removal must expose the inner region, not the outer one. The stimulus builds this stack layer by layer and gives every layer a distinct cacheable and bufferable pattern, so the attributes alone show which region won. After each layer is added or disabled, the bench probes the same address. A second hard corner is the full permission matrix. It crosses the four codes with both privilege levels and all three legal access kinds on one region, with both attribute bits set, so a wrongly granted access would show nonzero attributes.

// File: rtl/mpu_pkg.sv
package mpu_pkg;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_kind_e;

   typedef enum logic [1:0] {
      PERM_NONE    = 2'd0,
      PERM_PRIV    = 2'd1,
      PERM_USER_RO = 2'd2,
      PERM_FULL    = 2'd3
   } perm_e;

   // bit 3 bufferable, bit 2 cacheable, bits 1:0 permission
   typedef struct packed {
      logic  bufferable;
      logic  cacheable;
      perm_e perm;
   } attr_t;

   localparam int ATTR_W = $bits(attr_t);

   localparam logic [1:0] SEL_GEOM  = 2'd0;
   localparam logic [1:0] SEL_IATTR = 2'd1;
   localparam logic [1:0] SEL_DATTR = 2'd2;

endpackage

// File: rtl/mpu_region_regs.sv
module mpu_region_regs
   import mpu_pkg::*;
#(
   parameter int NUM_REGIONS = 8,
   parameter int ADDR_W      = 32,
   parameter int MIN_LOG2    = 12,
   localparam int IDX_W      = $clog2(NUM_REGIONS),
   localparam int SIZE_W     = $clog2(ADDR_W + 1)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cfg_we,
   input  logic [IDX_W-1:0]              cfg_idx,
   input  logic [1:0]                    cfg_sel,
   input  logic [ADDR_W-1:0]             cfg_wdata,
   output logic [NUM_REGIONS-1:0]        en_vec,
   output logic [NUM_REGIONS*ADDR_W-1:0] base_flat,
   output logic [NUM_REGIONS*SIZE_W-1:0] size_flat,
   output logic [NUM_REGIONS*ATTR_W-1:0] iattr_flat,
   output logic [NUM_REGIONS*ATTR_W-1:0] dattr_flat
);

   localparam logic [SIZE_W-1:0] SZ_MIN = SIZE_W'(MIN_LOG2);
   localparam logic [SIZE_W-1:0] SZ_MAX = SIZE_W'(ADDR_W);
   localparam logic [ADDR_W-1:0] BASE_MASK = ~((ADDR_W'(1) << MIN_LOG2) - ADDR_W'(1));

   logic [SIZE_W-1:0] size_field;
   logic [SIZE_W-1:0] size_clamped;
   logic [ADDR_W-1:0] base_field;
   attr_t             attr_field;
   logic              unused_wdata;

   assign size_field = cfg_wdata[SIZE_W:1];
   assign base_field = cfg_wdata & BASE_MASK;
   assign attr_field = attr_t'(cfg_wdata[ATTR_W-1:0]);

   always_comb begin
      if (size_field < SZ_MIN)
         size_clamped = SZ_MIN;
      else if (size_field > SZ_MAX)
         size_clamped = SZ_MAX;
      else
         size_clamped = size_field;
   end

   assign unused_wdata = ^cfg_wdata;

   for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
      logic              en_q;
      logic [ADDR_W-1:0] base_q;
      logic [SIZE_W-1:0] size_q;
      attr_t             iattr_q;
      attr_t             dattr_q;
      logic              sel_me;

      assign sel_me = cfg_we && (cfg_idx == IDX_W'(r));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en_q    <= 1'b0;
            base_q  <= '0;
            size_q  <= SZ_MIN;
            iattr_q <= '0;
            dattr_q <= '0;
         end else if (sel_me) begin
            case (cfg_sel)
               SEL_GEOM: begin
                  en_q   <= cfg_wdata[0];
                  size_q <= size_clamped;
                  base_q <= base_field;
               end
               SEL_IATTR: iattr_q <= attr_field;
               SEL_DATTR: dattr_q <= attr_field;
               default: ;
            endcase
         end
      end

      assign en_vec[r]                        = en_q;
      assign base_flat[r*ADDR_W +: ADDR_W]    = base_q;
      assign size_flat[r*SIZE_W +: SIZE_W]    = size_q;
      assign iattr_flat[r*ATTR_W +: ATTR_W]   = iattr_q;
      assign dattr_flat[r*ATTR_W +: ATTR_W]   = dattr_q;
   end

endmodule

// File: rtl/mpu_region_match.sv
module mpu_region_match #(
   parameter int ADDR_W = 32,
   localparam int SIZE_W = $clog2(ADDR_W + 1)
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] base,
   input  logic [SIZE_W-1:0] size_log2,
   input  logic              en,
   output logic              hit
);

   logic [ADDR_W:0]   span;
   logic [ADDR_W-1:0] keep_mask;
   logic              unused_span_top;

   // span = 2^size; for size == ADDR_W the low part is zero and the mask collapses to zero
   assign span            = (ADDR_W + 1)'(1) << size_log2;
   assign keep_mask       = ~(span[ADDR_W-1:0] - ADDR_W'(1));
   assign unused_span_top = span[ADDR_W];
   assign hit             = en && (((addr ^ base) & keep_mask) == '0);

endmodule

// File: rtl/mpu_priority_pick.sv
module mpu_priority_pick #(
   parameter int NUM_REGIONS = 8,
   localparam int IDX_W = $clog2(NUM_REGIONS)
) (
   input  logic [NUM_REGIONS-1:0] hit_vec,
   output logic                   any_hit,
   output logic [IDX_W-1:0]       win_idx
);

   always_comb begin
      any_hit = 1'b0;
      win_idx = '0;
      for (int i = 0; i < NUM_REGIONS; i++) begin
         if (hit_vec[i]) begin
            any_hit = 1'b1;
            win_idx = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/mpu_perm_check.sv
module mpu_perm_check
   import mpu_pkg::*;
(
   input  perm_e perm,
   input  logic  priv,
   input  logic  is_write,
   output logic  deny
);

   always_comb begin
      case (perm)
         PERM_NONE:    deny = 1'b1;
         PERM_PRIV:    deny = !priv;
         PERM_USER_RO: deny = !priv && is_write;
         PERM_FULL:    deny = 1'b0;
         default:      deny = 1'b1;
      endcase
   end

endmodule

// File: rtl/mpu_region_check.sv
module mpu_region_check
   import mpu_pkg::*;
#(
   parameter int NUM_REGIONS = 8,
   parameter int ADDR_W      = 32,
   parameter int MIN_LOG2    = 12,
   localparam int IDX_W      = $clog2(NUM_REGIONS),
   localparam int SIZE_W     = $clog2(ADDR_W + 1),
   localparam int SNAP_W     = NUM_REGIONS * (1 + ADDR_W + SIZE_W + 2 * ATTR_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [1:0]        cfg_sel,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_priv,
   input  logic [1:0]        req_kind,
   output logic              rsp_abort,
   output logic              rsp_cacheable,
   output logic              rsp_bufferable
);

   initial begin
      assert (NUM_REGIONS >= 2)
         else $error("NUM_REGIONS must be at least 2");
      assert (MIN_LOG2 < ADDR_W)
         else $error("MIN_LOG2 must be below ADDR_W");
      assert (SIZE_W + 1 <= MIN_LOG2)
         else $error("size field overlaps base field");
      assert (ATTR_W <= ADDR_W)
         else $error("attribute word wider than data");
   end

   logic [NUM_REGIONS-1:0]        en_vec;
   logic [NUM_REGIONS*ADDR_W-1:0] base_flat;
   logic [NUM_REGIONS*SIZE_W-1:0] size_flat;
   logic [NUM_REGIONS*ATTR_W-1:0] iattr_flat;
   logic [NUM_REGIONS*ATTR_W-1:0] dattr_flat;
   logic [NUM_REGIONS-1:0]        hit_vec;
   logic                          hit_any;
   logic [IDX_W-1:0]              win_idx;
   attr_t                         sel_attr;
   perm_e                         sel_perm;
   logic                          deny;
   logic                          kind_bad;
   logic                          is_fetch;
   logic [SNAP_W-1:0]             cfg_snapshot;

   mpu_region_regs #(
      .NUM_REGIONS(NUM_REGIONS),
      .ADDR_W     (ADDR_W),
      .MIN_LOG2   (MIN_LOG2)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_idx   (cfg_idx),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .en_vec    (en_vec),
      .base_flat (base_flat),
      .size_flat (size_flat),
      .iattr_flat(iattr_flat),
      .dattr_flat(dattr_flat)
   );

   for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_match
      mpu_region_match #(
         .ADDR_W(ADDR_W)
      ) u_match (
         .addr     (req_addr),
         .base     (base_flat[r*ADDR_W +: ADDR_W]),
         .size_log2(size_flat[r*SIZE_W +: SIZE_W]),
         .en       (en_vec[r]),
         .hit      (hit_vec[r])
      );
   end

   mpu_priority_pick #(
      .NUM_REGIONS(NUM_REGIONS)
   ) u_pick (
      .hit_vec(hit_vec),
      .any_hit(hit_any),
      .win_idx(win_idx)
   );

   assign is_fetch = (req_kind == ACC_FETCH);
   assign kind_bad = (req_kind == ACC_RSVD);

   always_comb begin
      if (is_fetch)
         sel_attr = attr_t'(iattr_flat[win_idx*ATTR_W +: ATTR_W]);
      else
         sel_attr = attr_t'(dattr_flat[win_idx*ATTR_W +: ATTR_W]);
   end

   assign sel_perm = sel_attr.perm;

   mpu_perm_check u_perm (
      .perm    (sel_perm),
      .priv    (req_priv),
      .is_write(req_kind == ACC_WRITE),
      .deny    (deny)
   );

   assign rsp_abort      = !hit_any || kind_bad || deny;
   assign rsp_cacheable  = !rsp_abort && sel_attr.cacheable;
   assign rsp_bufferable = !rsp_abort && sel_attr.bufferable;

   assign cfg_snapshot = {en_vec, base_flat, size_flat, iattr_flat, dattr_flat};

endmodule

// File: rtl/mpu_region_check_sva.sv
module mpu_region_check_sva #(
   parameter int NUM_REGIONS = 8,
   parameter int SNAP_W      = 8
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   cfg_we,
   input logic [1:0]             cfg_sel,
   input logic [1:0]             req_kind,
   input logic                   rsp_abort,
   input logic                   rsp_cacheable,
   input logic                   rsp_bufferable,
   input logic                   hit_any,
   input logic [1:0]             sel_perm,
   input logic [NUM_REGIONS-1:0] en_vec,
   input logic [SNAP_W-1:0]      cfg_snapshot
);

   // R1: reset leaves all regions disabled
   a_r1_reset_disables: assert property (@(posedge clk)
      !rst_n |=> (en_vec == '0));

   // R4: no enabled region covers the address
   a_r4_miss_aborts: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_any |-> rsp_abort);

   // R5: code 0 in the governing region
   a_r5_no_access_aborts: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_any && sel_perm == 2'd0) |-> rsp_abort);

   // R7: aborted accesses carry no attributes
   a_r7_abort_clears_attrs: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_abort |-> (!rsp_cacheable && !rsp_bufferable));

   // R8: reserved access kind
   a_r8_reserved_kind: assert property (@(posedge clk) disable iff (!rst_n)
      (req_kind == 2'd3) |-> rsp_abort);

   // R9: selector 3 writes leave configuration untouched
   a_r9_sel3_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel == 2'd3) |=> $stable(cfg_snapshot));

endmodule

bind mpu_region_check mpu_region_check_sva #(
   .NUM_REGIONS(NUM_REGIONS),
   .SNAP_W     (SNAP_W)
) u_sva (
   .clk           (clk),
   .rst_n         (rst_n),
   .cfg_we        (cfg_we),
   .cfg_sel       (cfg_sel),
   .req_kind      (req_kind),
   .rsp_abort     (rsp_abort),
   .rsp_cacheable (rsp_cacheable),
   .rsp_bufferable(rsp_bufferable),
   .hit_any       (hit_any),
   .sel_perm      (sel_perm),
   .en_vec        (en_vec),
   .cfg_snapshot  (cfg_snapshot)
);

// File: tb/tb_mpu_region_check.sv
module tb_mpu_region_check;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_idx = '0;
   logic [1:0]  cfg_sel = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] req_addr = '0;
   logic        req_priv = 1'b1;
   logic [1:0]  req_kind = '0;
   logic        rsp_abort;
   logic        rsp_cacheable;
   logic        rsp_bufferable;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   mpu_region_check dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_we        (cfg_we),
      .cfg_idx       (cfg_idx),
      .cfg_sel       (cfg_sel),
      .cfg_wdata     (cfg_wdata),
      .req_addr      (req_addr),
      .req_priv      (req_priv),
      .req_kind      (req_kind),
      .rsp_abort     (rsp_abort),
      .rsp_cacheable (rsp_cacheable),
      .rsp_bufferable(rsp_bufferable)
   );

   function automatic logic [31:0] geom(input logic [31:0] base, input int s, input bit en);
      return base | (32'(s & 63) << 1) | 32'(en);
   endfunction

   function automatic logic [31:0] attr(input bit c, input bit b, input int perm);
      return {28'd0, b, c, 2'(perm)};
   endfunction

   task automatic wr(input int idx, input int sel, input logic [31:0] data);
      cfg_idx   = 3'(idx);
      cfg_sel   = 2'(sel);
      cfg_wdata = data;
      cfg_we    = 1'b1;
      @(posedge clk);
      #1 cfg_we = 1'b0;
   endtask

   task automatic look(input string tag, input logic [31:0] a, input bit priv, input int kind,
                       input bit ea, input bit ec, input bit eb);
      req_addr = a;
      req_priv = priv;
      req_kind = 2'(kind);
      #2;
      checks++;
      if ({rsp_abort, rsp_cacheable, rsp_bufferable} !== {ea, ec, eb}) begin
         errors++;
         $display("FAIL %s addr=%h priv=%0d kind=%0d got abort/c/b=%b%b%b expected %b%b%b",
                  tag, a, priv, kind, rsp_abort, rsp_cacheable, rsp_bufferable, ea, ec, eb);
      end
   endtask

   task automatic t_reset();
      look("R1 reset read", 32'h0000_0000, 1, 0, 1, 0, 0);
      look("R1 reset fetch", 32'hFFFF_F000, 1, 2, 1, 0, 0);
      look("R1 reset write", 32'h1234_5678, 0, 1, 1, 0, 0);
   endtask

   task automatic t_geometry();
      wr(0, 2, attr(1, 1, 3));
      wr(0, 0, geom(32'h0000_1000, 12, 1));
      look("R2 4KB low edge", 32'h0000_1000, 1, 0, 0, 1, 1);
      look("R2 4KB high edge", 32'h0000_1FFF, 0, 1, 0, 1, 1);
      look("R4 above 4KB", 32'h0000_2000, 1, 0, 1, 0, 0);
      look("R4 below 4KB", 32'h0000_0FFF, 1, 0, 1, 0, 0);
      wr(1, 2, attr(0, 1, 3));
      wr(1, 0, geom(32'h0001_8000, 16, 1));
      look("R2 unaligned base low", 32'h0001_0000, 1, 0, 0, 0, 1);
      look("R2 unaligned base high", 32'h0001_FFFF, 1, 0, 0, 0, 1);
      look("R4 past 64KB", 32'h0002_0000, 1, 0, 1, 0, 0);
      wr(2, 2, attr(1, 0, 3));
      wr(2, 0, geom(32'h0004_0000, 3, 1));
      look("R2 clamp small in", 32'h0004_0FFF, 1, 0, 0, 1, 0);
      look("R2 clamp small out", 32'h0004_1000, 1, 0, 1, 0, 0);
   endtask

   task automatic t_priority();
      wr(3, 2, attr(1, 0, 3));
      wr(3, 0, geom(32'h0010_0000, 20, 1));
      wr(6, 2, attr(0, 1, 3));
      wr(6, 0, geom(32'h0010_4000, 14, 1));
      look("R3 inner wins", 32'h0010_4010, 1, 0, 0, 0, 1);
      look("R3 outer only", 32'h0010_0010, 1, 0, 0, 1, 0);
      wr(7, 2, attr(1, 1, 3));
      wr(7, 0, geom(32'h0000_0000, 63, 1));
      look("R3 top region wins", 32'h0010_4010, 1, 0, 0, 1, 1);
      look("R2 clamp to 4GB", 32'hFFFF_FFF0, 0, 1, 0, 1, 1);
      wr(7, 0, geom(32'h0000_0000, 63, 0));
      look("R3 disable top", 32'h0010_4010, 1, 0, 0, 0, 1);
      look("R4 after disable", 32'hFFFF_FFF0, 1, 0, 1, 0, 0);
   endtask

   function automatic bit exp_deny(input int perm, input bit priv, input int kind);
      case (perm)
         0: return 1'b1;
         1: return !priv;
         2: return !priv && (kind == 1);
         default: return 1'b0;
      endcase
   endfunction

   task automatic t_perm();
      wr(4, 0, geom(32'h0200_0000, 12, 1));
      for (int p = 0; p < 4; p++) begin
         wr(4, 1, attr(1, 1, p));
         wr(4, 2, attr(1, 1, p));
         for (int pv = 0; pv < 2; pv++) begin
            for (int k = 0; k < 3; k++) begin
               bit d = exp_deny(p, pv[0], k);
               look($sformatf("R5 perm %0d", p), 32'h0200_0100, pv[0], k, d, !d, !d);
            end
         end
      end
   endtask

   task automatic t_sides();
      wr(4, 1, attr(1, 0, 3));
      wr(4, 2, attr(0, 1, 3));
      look("R6 fetch uses instr set", 32'h0200_0200, 0, 2, 0, 1, 0);
      look("R6 read uses data set", 32'h0200_0200, 0, 0, 0, 0, 1);
      look("R6 write uses data set", 32'h0200_0200, 0, 1, 0, 0, 1);
      wr(4, 1, attr(1, 1, 0));
      look("R6 fetch perm from instr set", 32'h0200_0200, 1, 2, 1, 0, 0);
      look("R7 data still allowed", 32'h0200_0200, 1, 0, 0, 0, 1);
      wr(4, 1, attr(1, 0, 3));
   endtask

   task automatic t_reserved();
      look("R8 reserved kind priv", 32'h0200_0200, 1, 3, 1, 0, 0);
      look("R8 reserved kind user", 32'h0010_4010, 0, 3, 1, 0, 0);
   endtask

   task automatic t_sel3();
      wr(4, 3, 32'h0000_0000);
      wr(6, 3, 32'hFFFF_FFFF);
      look("R9 region4 unchanged", 32'h0200_0200, 0, 2, 0, 1, 0);
      look("R9 region6 unchanged", 32'h0010_4010, 1, 0, 0, 0, 1);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_geometry();
      t_priority();
      t_perm();
      t_sides();
      t_reserved();
      t_sel3();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule